// File: doc/BRIEF.md
# Multi-hit event timestamp capture

This block records the arrival time of every rising edge seen on a hit line. A time base runs without pause from a single fast clock. Its fine part is a Johnson counter whose shifting pattern is decoded into a small binary phase code. Its coarse part is a binary counter that advances once each time the Johnson counter completes its cycle. Together they form one timestamp, `{coarse, fine}`, whose value equals the number of clock edges since reset, taken modulo its width.

The hit line may be asynchronous. It passes through a flop synchroniser and a rising-edge detector. Each detected edge writes the timestamp of that cycle into an internal FIFO. Hits are never paired into start and stop, so any number of hits may follow one another. A consumer drains the FIFO through a valid/ready port. When the FIFO is full, new hits are discarded and a sticky overflow flag is raised. Software-free logic clears that flag through a dedicated input.

The fine and coarse values are both registered state that changes on the same edge. Because of this, a capture always stores a consistent pair, including in the cycle where the Johnson pattern returns to all zeros and the coarse count steps.

Top module: `hit_stamp_top`

## Requirements
- R1: After a synchronous reset, `ts_valid` and `ovf_flag` are 0 and the time base is zero. Counting starts at 1 on the first clock edge with `rst` low.
- R2: The fine code advances by one on every clock and wraps from 2*JSTAGES-1 to 0. It is decoded from a Johnson counter whose state changes in exactly one bit per clock.
- R3: The coarse count increments only on the clock where the fine code goes from its last value to 0, and it wraps modulo 2^COARSE_W. With defaults the timestamp `ts_data[18:3]` is coarse and `ts_data[2:0]` is fine.
- R4: A low-to-high transition of `hit_in` creates exactly one FIFO entry. Holding the line high, or a high-to-low transition, creates none.
- R5: The stored timestamp equals T+2, where T is the time base value (`coarse*2*JSTAGES + fine`) in the cycle that ends with the clock edge that first samples `hit_in` high. This offset comes from the two synchroniser flops.
- R6: Hits separated by a single low sampled cycle are each captured, and they are read out in arrival order.
- R7: `ts_valid` is high exactly while the FIFO holds entries, and `ts_data` shows the oldest entry. An entry is removed on a clock where `ts_valid` and `ts_ready` are both high. While `ts_ready` is low, `ts_data` holds.
- R8: The FIFO holds FIFO_DEPTH entries, 16 by default. A hit that arrives while it is full is dropped and sets `ovf_flag`, and the stored entries are left unchanged.
- R9: `ovf_flag` stays set until `ovf_clear` is high on a clock with no drop. If a drop and a clear fall on the same clock, the flag stays set. Clearing has no effect on the FIFO.
- R10: A write and a read on the same clock, when the FIFO is not full, both take effect with no loss or reordering.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock for the time base, synchroniser and FIFO |
| rst | input | 1 | Synchronous active-high reset |
| hit_in | input | 1 | Asynchronous hit line; rising edges are stamped |
| ovf_clear | input | 1 | Clears the sticky overflow flag |
| ts_valid | output | 1 | FIFO holds at least one timestamp |
| ts_ready | input | 1 | Consumer accepts the timestamp on `ts_data` |
| ts_data | output | COARSE_W+log2(2*JSTAGES) | Oldest timestamp, coarse above fine |
| ovf_flag | output | 1 | Sticky flag: a hit was dropped while the FIFO was full |

## Verification
The properties make no assumption about the timing of `hit_in`, `ts_ready` or `ovf_clear`. They take for granted only that reset is asserted at the start. The one-entry-per-edge and hold-while-stalled checks rely on the FIFO being the only path that moves `ts_data`. The bench changes every input one time unit after a rising clock edge and holds each hit level for at least one full cycle, so each pulse is seen exactly once by the synchroniser. In the random phase, hit gaps and a mostly-high `ts_ready` keep the FIFO well short of full. Overflow is reached only in a directed phase where the bench knows the exact occupancy.

// File: rtl/hit_stamp_pkg.sv
package hit_stamp_pkg;

  // Widest Johnson counter the helper functions accept.
  localparam int JMAX = 32;

  // Number of bits of the fine phase code for an n-stage Johnson counter.
  function automatic int fine_bits(input int n);
    return $clog2(2 * n);
  endfunction

  // Count of set bits among the low n stages.
  function automatic int stage_ones(input logic [JMAX-1:0] st, input int n);
    int ones;
    ones = 0;
    for (int i = 0; i < JMAX; i++) begin
      if (i < n && st[i]) ones++;
    end
    return ones;
  endfunction

  // Phase code from a Johnson pattern: while the top stage is clear the
  // code is the number of ones filled in from the bottom; once it is set
  // the ones drain from the bottom and the code keeps rising.
  function automatic int johnson_to_fine(input logic [JMAX-1:0] st, input int n);
    int ones;
    ones = stage_ones(st, n);
    if (st[n-1]) return 2 * n - ones;
    return ones;
  endfunction

  // One shift step: the inverted top stage enters at the bottom.
  function automatic logic [JMAX-1:0] johnson_advance(input logic [JMAX-1:0] st, input int n);
    logic [JMAX-1:0] nxt;
    nxt = '0;
    for (int i = 0; i < JMAX; i++) begin
      if (i < n) begin
        if (i == 0) nxt[i] = ~st[n-1];
        else        nxt[i] = st[i-1];
      end
    end
    return nxt;
  endfunction

  // True on the last pattern of the cycle (only the top stage set),
  // after which the counter returns to all zeros.
  function automatic logic johnson_at_end(input logic [JMAX-1:0] st, input int n);
    return st[n-1] && (stage_ones(st, n) == 1);
  endfunction

endpackage

// File: rtl/hs_timebase.sv
module hs_timebase
  import hit_stamp_pkg::*;
#(
  parameter int JSTAGES  = 4,
  parameter int COARSE_W = 16,
  parameter int FINE_W   = 3
) (
  input  logic                clk,
  input  logic                rst,
  output logic [JSTAGES-1:0]  jstate,
  output logic [FINE_W-1:0]   fine,
  output logic [COARSE_W-1:0] coarse,
  output logic                cycle_end
);

  logic [JMAX-1:0] jwide;
  logic [JMAX-1:0] jnext_wide;

  assign jwide      = {{(JMAX-JSTAGES){1'b0}}, jstate};
  assign jnext_wide = johnson_advance(jwide, JSTAGES);
  assign cycle_end  = johnson_at_end(jwide, JSTAGES);
  assign fine       = FINE_W'(johnson_to_fine(jwide, JSTAGES));

  // Coarse steps on the same edge on which the Johnson pattern returns to
  // zero, so both halves of the timestamp always belong to one cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      jstate <= '0;
      coarse <= '0;
    end else begin
      jstate <= jnext_wide[JSTAGES-1:0];
      if (cycle_end) coarse <= coarse + 1'b1;
    end
  end

endmodule

// File: rtl/hs_hit_edge.sv
module hs_hit_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic hit_async,
  output logic hit_rise
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], hit_async};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign hit_rise = sync_q[SYNC_STAGES-1] & ~last_q;

endmodule

// File: rtl/hs_fifo.sv
module hs_fifo #(
  parameter int WIDTH = 19,
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int LW    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_req,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  output logic             push_ok,
  output logic             push_drop,
  output logic             pop_fire,
  output logic             full,
  output logic [LW-1:0]    level
);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign full      = (level == LW'(DEPTH));
  assign out_valid = (level != '0);
  assign out_data  = store[rd_ptr];
  assign push_ok   = push_req & ~full;
  assign push_drop = push_req & full;
  assign pop_fire  = pop_req & out_valid;

  always_ff @(posedge clk) begin
    if (push_ok) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok)  wr_ptr <= ptr_step(wr_ptr);
      if (pop_fire) rd_ptr <= ptr_step(rd_ptr);
      case ({push_ok, pop_fire})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/hit_stamp_top.sv
module hit_stamp_top
  import hit_stamp_pkg::*;
#(
  parameter  int JSTAGES     = 4,
  parameter  int COARSE_W    = 16,
  parameter  int FIFO_DEPTH  = 16,
  parameter  int SYNC_STAGES = 2,
  localparam int FINE_W      = fine_bits(JSTAGES),
  localparam int STAMP_W     = COARSE_W + FINE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hit_in,
  input  logic               ovf_clear,
  output logic               ts_valid,
  input  logic               ts_ready,
  output logic [STAMP_W-1:0] ts_data,
  output logic               ovf_flag
);

  localparam int AW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int LW = $clog2(FIFO_DEPTH + 1);

  // Named internal events, visible to the bound checker.
  logic [JSTAGES-1:0]  jstate;
  logic [FINE_W-1:0]   fine;
  logic [COARSE_W-1:0] coarse;
  logic                cycle_end;
  logic                cap_req;
  logic                cap_write;
  logic                cap_drop;
  logic                rd_fire;
  logic                fifo_full;
  logic [LW-1:0]       fifo_level;
  logic [STAMP_W-1:0]  stamp_now;

  hs_timebase #(
    .JSTAGES  (JSTAGES),
    .COARSE_W (COARSE_W),
    .FINE_W   (FINE_W)
  ) u_timebase (
    .clk       (clk),
    .rst       (rst),
    .jstate    (jstate),
    .fine      (fine),
    .coarse    (coarse),
    .cycle_end (cycle_end)
  );

  hs_hit_edge #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_edge (
    .clk       (clk),
    .rst       (rst),
    .hit_async (hit_in),
    .hit_rise  (cap_req)
  );

  assign stamp_now = {coarse, fine};

  hs_fifo #(
    .WIDTH (STAMP_W),
    .DEPTH (FIFO_DEPTH),
    .AW    (AW),
    .LW    (LW)
  ) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push_req  (cap_req),
    .push_data (stamp_now),
    .pop_req   (ts_ready),
    .out_valid (ts_valid),
    .out_data  (ts_data),
    .push_ok   (cap_write),
    .push_drop (cap_drop),
    .pop_fire  (rd_fire),
    .full      (fifo_full),
    .level     (fifo_level)
  );

  // Sticky drop flag: a drop in the same cycle as a clear wins.
  always_ff @(posedge clk) begin
    if (rst)            ovf_flag <= 1'b0;
    else if (cap_drop)  ovf_flag <= 1'b1;
    else if (ovf_clear) ovf_flag <= 1'b0;
  end

endmodule

// File: rtl/hs_checker.sv
module hs_checker #(
  parameter int JSTAGES  = 4,
  parameter int COARSE_W = 16,
  parameter int FINE_W   = 3,
  parameter int STAMP_W  = 19,
  parameter int DEPTH    = 16,
  parameter int LW       = 5
) (
  input logic                clk,
  input logic                rst,
  input logic [JSTAGES-1:0]  jstate,
  input logic [FINE_W-1:0]   fine,
  input logic [COARSE_W-1:0] coarse,
  input logic                cycle_end,
  input logic                cap_req,
  input logic                cap_drop,
  input logic                fifo_full,
  input logic [LW-1:0]       fifo_level,
  input logic                ts_valid,
  input logic                ts_ready,
  input logic [STAMP_W-1:0]  ts_data,
  input logic                ovf_flag,
  input logic                ovf_clear
);

  localparam logic [FINE_W-1:0] FINE_LAST = FINE_W'(2 * JSTAGES - 1);

  p_johnson_step_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones(jstate ^ $past(jstate)) == 1);

  p_fine_step_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> fine == (($past(fine) == FINE_LAST) ? '0 : $past(fine) + 1'b1));

  p_coarse_step_r3: assert property (@(posedge clk) disable iff (rst)
    cycle_end |=> coarse == $past(coarse) + 1'b1);

  p_coarse_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !cycle_end |=> $stable(coarse));

  p_end_at_last_fine_r3: assert property (@(posedge clk) disable iff (rst)
    cycle_end |-> fine == FINE_LAST);

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    cap_req |=> !cap_req);

  p_hold_when_stalled_r7: assert property (@(posedge clk) disable iff (rst)
    ts_valid && !ts_ready |=> ts_valid && $stable(ts_data));

  p_valid_level_r7: assert property (@(posedge clk) disable iff (rst)
    ts_valid == (fifo_level != '0));

  p_level_bound_r8: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= LW'(DEPTH));

  p_drop_only_full_r8: assert property (@(posedge clk) disable iff (rst)
    cap_drop |-> fifo_full && cap_req);

  p_drop_sets_flag_r8: assert property (@(posedge clk) disable iff (rst)
    cap_drop |=> ovf_flag);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    ovf_flag && !ovf_clear |=> ovf_flag);

endmodule

bind hit_stamp_top hs_checker #(
  .JSTAGES  (JSTAGES),
  .COARSE_W (COARSE_W),
  .FINE_W   (FINE_W),
  .STAMP_W  (STAMP_W),
  .DEPTH    (FIFO_DEPTH),
  .LW       (LW)
) u_checker (
  .clk        (clk),
  .rst        (rst),
  .jstate     (jstate),
  .fine       (fine),
  .coarse     (coarse),
  .cycle_end  (cycle_end),
  .cap_req    (cap_req),
  .cap_drop   (cap_drop),
  .fifo_full  (fifo_full),
  .fifo_level (fifo_level),
  .ts_valid   (ts_valid),
  .ts_ready   (ts_ready),
  .ts_data    (ts_data),
  .ovf_flag   (ovf_flag),
  .ovf_clear  (ovf_clear)
);

// File: tb/hit_stamp_top_test.sv
`timescale 1ns/1ps
module hit_stamp_top_test;

  localparam int SW   = 19;   // default stamp width
  localparam int SW_W = 5;    // stamp width of the small-coarse instance

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hit = 1'b0;
  logic          clr = 1'b0;
  logic          rdy = 1'b0;
  logic          vld;
  logic [SW-1:0] data;
  logic          ovf;
  logic          vld_w;
  logic [SW_W-1:0] data_w;
  logic          ovf_w;

  int      n_chk = 0;
  int      n_bad = 0;
  bit      done = 1'b0;
  bit      rnd_rdy = 1'b0;
  longint  tcnt = 0;
  logic [SW-1:0] expq[$];

  always #2.5 clk = ~clk;

  hit_stamp_top uut (
    .clk(clk), .rst(rst), .hit_in(hit), .ovf_clear(clr),
    .ts_valid(vld), .ts_ready(rdy), .ts_data(data), .ovf_flag(ovf)
  );

  // Second copy with a 2-bit coarse count so the wrap is reached quickly.
  hit_stamp_top #(.COARSE_W(2)) uut_w (
    .clk(clk), .rst(rst), .hit_in(hit), .ovf_clear(1'b0),
    .ts_valid(vld_w), .ts_ready(1'b0), .ts_data(data_w), .ovf_flag(ovf_w)
  );

  // Bench time: edges since reset release.
  always @(posedge clk) begin
    if (rst) tcnt <= 0;
    else     tcnt <= tcnt + 1;
  end

  function automatic logic [SW-1:0] stamp_of(input longint t);
    return SW'(t + 2);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
      if (rnd_rdy) rdy = (($urandom % 4) != 0);
    end
  endtask

  task automatic pulse_hit(input int hi, input int lo, input bit stored);
    hit = 1'b1;
    if (stored) expq.push_back(stamp_of(tcnt));
    tick(hi);
    hit = 1'b0;
    tick(lo);
  endtask

  // Read monitor: every accepted entry is compared with the bench queue (R5, R6, R10).
  always @(negedge clk) begin
    if (!rst && vld && rdy) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R4", "unexpected entry", longint'(data), -1);
      end else begin
        chk(data == expq[0], "R5", "timestamp", longint'(data), longint'(expq[0]));
        void'(expq.pop_front());
      end
    end
  end

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] held;
    logic [SW-1:0] first;
    void'($urandom(32'd5171));
    tick(4);
    rst = 1'b0;
    tick(1);
    // R1: reset state at the ports.
    chk(vld == 1'b0, "R1", "ts_valid after reset", longint'(vld), 0);
    chk(ovf == 1'b0, "R1", "ovf_flag after reset", longint'(ovf), 0);
    chk(vld_w == 1'b0, "R1", "small ts_valid after reset", longint'(vld_w), 0);
    chk(tcnt == 1, "R1", "bench time base start", tcnt, 1);

    // Stalled reader, several hits with differing gaps (R5, R6).
    tick(40);
    first = stamp_of(tcnt);
    pulse_hit(1, 3, 1'b1);
    pulse_hit(1, 1, 1'b1);
    pulse_hit(2, 1, 1'b1);
    pulse_hit(1, 5, 1'b1);
    pulse_hit(3, 2, 1'b1);
    tick(3);
    chk(vld == 1'b1, "R7", "valid with entries", longint'(vld), 1);
    chk(data == first, "R5", "oldest shown", longint'(data), longint'(first));
    // R3: coarse wrap in the 2-bit instance, modulo 32 cycles.
    chk(data_w == SW_W'(first), "R3", "wrapped stamp", longint'(data_w), longint'(SW_W'(first)));
    held = data;
    tick(6);
    chk(data == held, "R7", "data held while stalled", longint'(data), longint'(held));

    // R4: a long high level gives one entry, the falling edge none.
    hit = 1'b1;
    expq.push_back(stamp_of(tcnt));
    tick(10);
    hit = 1'b0;
    tick(6);
    rdy = 1'b1;
    tick(20);
    rdy = 1'b0;
    chk(vld == 1'b0, "R4", "no extra entries", longint'(vld), 0);
    chk(expq.size() == 0, "R6", "all hits read", expq.size(), 0);

    // R8: fill all 16 places, then overflow.
    for (int i = 0; i < 16; i++) pulse_hit(1, 1, 1'b1);
    tick(3);
    chk(ovf == 1'b0, "R8", "no flag when just full", longint'(ovf), 0);
    // R9: a drop and a clear on the same clock leave the flag set.
    hit = 1'b1;
    tick(1);
    hit = 1'b0;
    tick(1);
    clr = 1'b1;
    tick(1);
    clr = 1'b0;
    chk(ovf == 1'b1, "R9", "drop wins over clear", longint'(ovf), 1);
    clr = 1'b1;
    tick(1);
    clr = 1'b0;
    chk(ovf == 1'b0, "R9", "clear alone", longint'(ovf), 0);
    chk(vld == 1'b1, "R9", "clear keeps FIFO", longint'(vld), 1);
    pulse_hit(1, 4, 1'b0);
    chk(ovf == 1'b1, "R8", "drop sets flag", longint'(ovf), 1);
    tick(5);
    chk(ovf == 1'b1, "R9", "flag sticky", longint'(ovf), 1);
    rdy = 1'b1;
    tick(25);
    rdy = 1'b0;
    chk(expq.size() == 0, "R8", "stored entries intact", expq.size(), 0);
    chk(vld == 1'b0, "R8", "dropped hits absent", longint'(vld), 0);
    clr = 1'b1;
    tick(1);
    clr = 1'b0;
    chk(ovf == 1'b0, "R9", "flag cleared", longint'(ovf), 0);

    // Random hits with a random reader: simultaneous push and pop (R10, R6, R2).
    rnd_rdy = 1'b1;
    for (int i = 0; i < 400; i++) begin
      pulse_hit(1 + int'($urandom % 2), 1 + int'($urandom % 4), 1'b1);
    end
    rnd_rdy = 1'b0;
    rdy = 1'b1;
    tick(40);
    chk(expq.size() == 0, "R10", "random hits all read", expq.size(), 0);
    chk(vld == 1'b0, "R10", "drained", longint'(vld), 0);
    chk(ovf == 1'b0, "R10", "no drop in random phase", longint'(ovf), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule